// File: doc/BRIEF.md
# Decode-Stage Operand Bypass Selector

This block supplies the two source operands of the instruction sitting in the decode stage of a five-stage in-order pipeline. The five stages are fetch, decode, execute, memory and write-back. The register file is written only at write-back and read only in decode, so the one hazard left is read-after-write. For each read port the block compares the port's register number with the destinations of the instructions now in execute and in memory. It then hands on the most recent value of that register.

A producer one instruction ahead is still in execute, and its result is taken from the execute-stage result bus. A producer two instructions ahead sits in the memory stage, and its result is taken from that stage's result bus. A producer three instructions ahead is in write-back, and the register file's own write-through path already covers it, so the block passes the register file output on unchanged. Results that only exist after a data-memory access cannot be bypassed from execute. Detecting that case is left to a separate stall unit.

The selection is purely combinational. The decode/execute pipeline register captures the chosen operand on the same clock edge.

Top module: `opnd_bypass_sel`

## Requirements
- R1: A port whose read enable is 0 outputs all zeros, whatever its address and the stage buses carry.
- R2: A port reading register number 0 with read enable 1 outputs zero, even when the execute or memory stage is writing register 0.
- R3: When the port is enabled, the address is nonzero and the execute stage has write enable 1 with a matching destination, the port outputs the execute-stage result.
- R4: When the port is enabled, the address is nonzero, execute does not match and the memory stage has write enable 1 with a matching destination, the port outputs the memory-stage result.
- R5: When execute and memory both match the same port, the execute-stage result wins.
- R6: When the port is enabled, the address is nonzero and neither stage matches, the port outputs the register file data. The write-back case is included here and relies on the register file's write-through.
- R7: A stage whose write enable is 0 is ignored, even when its destination equals the read address.
- R8: The two ports are resolved independently, and each may select a different source in the same cycle.
- R9: In a pipeline built around the block, dependent OR-immediate chains at distances of one, two and three instructions leave every register with its sequential-execution value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rd_en_a | input | 1 | Read enable, port A |
| rd_addr_a | input | 5 | Register number, port A |
| rf_data_a | input | 32 | Register file output for port A (write-through included) |
| rd_en_b | input | 1 | Read enable, port B |
| rd_addr_b | input | 5 | Register number, port B |
| rf_data_b | input | 32 | Register file output for port B |
| ex_we | input | 1 | Execute-stage instruction writes a register |
| ex_waddr | input | 5 | Execute-stage destination |
| ex_wdata | input | 32 | Execute-stage result |
| mem_we | input | 1 | Memory-stage instruction writes a register |
| mem_waddr | input | 5 | Memory-stage destination |
| mem_wdata | input | 32 | Memory-stage result |
| opnd_a | output | 32 | Selected operand, port A |
| opnd_b | output | 32 | Selected operand, port B |

## Verification
The bench targets the following cases, each paired with the fault it would expose:
- Both stages naming the same register: a design with the priority reversed hands on stale memory-stage data.
- A destination of register 0: a design without the zero guard leaks a forwarded value into what should read as zero.
- A matching address with write enable low: a design that ignores the enable forwards garbage.
- A disabled port: a design that does not force zero passes the register file value through.

Random vectors over a tiny register range make the address collisions frequent. A small pipeline model in the bench then runs OR-immediate chains at distances one to three, plus a random program, and compares each final register with a sequential model. A missing bypass path shows up there as a wrong register value.

// File: rtl/bypass_pkg.sv
package bypass_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {SRC_NONE, SRC_RF, SRC_MEM, SRC_EX} src_e;

  // a stage counts as a producer for a reader only when both sides are enabled
  // and the register is a real one
  function automatic logic stage_hits(input logic we, input logic [ADDR_W-1:0] waddr,
                                      input logic en, input logic [ADDR_W-1:0] raddr);
    return en && we && (raddr != '0) && (raddr == waddr);
  endfunction

  // newest producer wins: execute is younger than memory
  function automatic src_e pick_src(input logic en, input logic zero_reg,
                                    input logic ex_hit, input logic mem_hit);
    if (!en || zero_reg) return SRC_NONE;
    if (ex_hit)          return SRC_EX;
    if (mem_hit)         return SRC_MEM;
    return SRC_RF;
  endfunction
endpackage

// File: rtl/bypass_match.sv
module bypass_match
  import bypass_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  input  logic          ex_we,
  input  logic [AW-1:0] ex_waddr,
  input  logic          mem_we,
  input  logic [AW-1:0] mem_waddr,
  output logic          ex_hit,
  output logic          mem_hit,
  output logic          zero_reg
);
  assign zero_reg = (rd_addr == '0);
  assign ex_hit   = stage_hits(ex_we, ex_waddr, rd_en, rd_addr);
  assign mem_hit  = stage_hits(mem_we, mem_waddr, rd_en, rd_addr);
endmodule

// File: rtl/bypass_port_sel.sv
module bypass_port_sel
  import bypass_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          rd_en,
  input  logic          zero_reg,
  input  logic          ex_hit,
  input  logic          mem_hit,
  input  logic [DW-1:0] rf_data,
  input  logic [DW-1:0] ex_wdata,
  input  logic [DW-1:0] mem_wdata,
  output logic [DW-1:0] opnd
);
  src_e src;

  assign src = pick_src(rd_en, zero_reg, ex_hit, mem_hit);

  always_comb begin
    unique case (src)
      SRC_EX:  opnd = ex_wdata;
      SRC_MEM: opnd = mem_wdata;
      SRC_RF:  opnd = rf_data;
      default: opnd = '0;
    endcase
  end

  // hit flags come from the match block; output comes from the mux here
  always_comb begin
    if (!$isunknown({rd_en, zero_reg, ex_hit, mem_hit, rf_data, ex_wdata, mem_wdata})) begin
      assert_off_port_zero_R1: assert (rd_en || opnd == '0)
        else $error("disabled port not zero");
      assert_reg0_zero_R2: assert (!(rd_en && zero_reg) || opnd == '0)
        else $error("register 0 not zero");
      assert_ex_taken_R3: assert (!ex_hit || opnd == ex_wdata)
        else $error("execute hit not taken");
      assert_mem_taken_R4: assert (!(mem_hit && !ex_hit) || opnd == mem_wdata)
        else $error("memory hit not taken");
      assert_rf_taken_R6: assert (!(rd_en && !zero_reg && !ex_hit && !mem_hit) || opnd == rf_data)
        else $error("register file data not taken");
    end
  end
endmodule

// File: rtl/opnd_bypass_sel.sv
module opnd_bypass_sel
  import bypass_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          rd_en_a,
  input  logic [AW-1:0] rd_addr_a,
  input  logic [DW-1:0] rf_data_a,
  input  logic          rd_en_b,
  input  logic [AW-1:0] rd_addr_b,
  input  logic [DW-1:0] rf_data_b,
  input  logic          ex_we,
  input  logic [AW-1:0] ex_waddr,
  input  logic [DW-1:0] ex_wdata,
  input  logic          mem_we,
  input  logic [AW-1:0] mem_waddr,
  input  logic [DW-1:0] mem_wdata,
  output logic [DW-1:0] opnd_a,
  output logic [DW-1:0] opnd_b
);
  localparam int NPORT = 2;

  logic [NPORT-1:0]         p_en;
  logic [NPORT-1:0][AW-1:0] p_addr;
  logic [NPORT-1:0][DW-1:0] p_rf;
  logic [NPORT-1:0][DW-1:0] p_out;
  logic [NPORT-1:0]         p_ex_hit, p_mem_hit, p_zero;

  assign p_en   = {rd_en_b, rd_en_a};
  assign p_addr = {rd_addr_b, rd_addr_a};
  assign p_rf   = {rf_data_b, rf_data_a};

  // R8: identical, independent resolution per read port
  for (genvar i = 0; i < NPORT; i++) begin : g_port
    bypass_match #(.AW(AW)) u_match (
      .rd_en    (p_en[i]),
      .rd_addr  (p_addr[i]),
      .ex_we    (ex_we),
      .ex_waddr (ex_waddr),
      .mem_we   (mem_we),
      .mem_waddr(mem_waddr),
      .ex_hit   (p_ex_hit[i]),
      .mem_hit  (p_mem_hit[i]),
      .zero_reg (p_zero[i])
    );
    bypass_port_sel #(.DW(DW)) u_sel (
      .rd_en    (p_en[i]),
      .zero_reg (p_zero[i]),
      .ex_hit   (p_ex_hit[i]),
      .mem_hit  (p_mem_hit[i]),
      .rf_data  (p_rf[i]),
      .ex_wdata (ex_wdata),
      .mem_wdata(mem_wdata),
      .opnd     (p_out[i])
    );
  end

  assign opnd_a = p_out[0];
  assign opnd_b = p_out[1];

  // R7: a stage with write enable low never produces a hit on either port
  always_comb begin
    if (!$isunknown({ex_we, mem_we, p_ex_hit, p_mem_hit})) begin
      assert_idle_ex_ignored_R7: assert (ex_we || p_ex_hit == '0)
        else $error("idle execute stage hit");
      assert_idle_mem_ignored_R7: assert (mem_we || p_mem_hit == '0)
        else $error("idle memory stage hit");
    end
  end
endmodule

// File: tb/sim_opnd_bypass_sel.sv
module sim_opnd_bypass_sel;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // direct stimulus
  logic        t_en_a, t_en_b, t_exwe, t_mwe;
  logic [4:0]  t_ad_a, t_ad_b, t_exa, t_ma;
  logic [31:0] t_rf_a, t_rf_b, t_exd, t_md;

  // pipeline model
  bit          pipe_mode = 1'b0, pipe_clr = 1'b1;
  logic [4:0]  prog_rs [64];
  logic [4:0]  prog_rt [64];
  logic [15:0] prog_im [64];
  int          prog_len = 0, pc = 0;
  logic        id_v, ex_v, mem_v, wb_v;
  logic [4:0]  id_rs, id_rt, ex_rt, mem_rt, wb_rt;
  logic [15:0] id_im, ex_im;
  logic [31:0] ex_opa, mem_res, wb_res, ex_res, rf_rd_a;
  logic [31:0] rf [8];

  assign ex_res  = ex_opa | {16'h0, ex_im};
  assign rf_rd_a = (wb_v && wb_rt == id_rs && id_rs != 5'd0) ? wb_res : rf[id_rs[2:0]];

  logic        d_en_a, d_en_b, d_exwe, d_mwe;
  logic [4:0]  d_ad_a, d_ad_b, d_exa, d_ma;
  logic [31:0] d_rf_a, d_rf_b, d_exd, d_md, o_a, o_b;

  assign d_en_a = pipe_mode ? id_v    : t_en_a;
  assign d_ad_a = pipe_mode ? id_rs   : t_ad_a;
  assign d_rf_a = pipe_mode ? rf_rd_a : t_rf_a;
  assign d_en_b = pipe_mode ? 1'b0    : t_en_b;
  assign d_ad_b = pipe_mode ? 5'd0    : t_ad_b;
  assign d_rf_b = pipe_mode ? 32'h0   : t_rf_b;
  assign d_exwe = pipe_mode ? ex_v    : t_exwe;
  assign d_exa  = pipe_mode ? ex_rt   : t_exa;
  assign d_exd  = pipe_mode ? ex_res  : t_exd;
  assign d_mwe  = pipe_mode ? mem_v   : t_mwe;
  assign d_ma   = pipe_mode ? mem_rt  : t_ma;
  assign d_md   = pipe_mode ? mem_res : t_md;

  opnd_bypass_sel u0 (
    .rd_en_a(d_en_a), .rd_addr_a(d_ad_a), .rf_data_a(d_rf_a),
    .rd_en_b(d_en_b), .rd_addr_b(d_ad_b), .rf_data_b(d_rf_b),
    .ex_we(d_exwe), .ex_waddr(d_exa), .ex_wdata(d_exd),
    .mem_we(d_mwe), .mem_waddr(d_ma), .mem_wdata(d_md),
    .opnd_a(o_a), .opnd_b(o_b)
  );

  always @(posedge clk) begin
    if (pipe_clr) begin
      pc <= 0; id_v <= 0; ex_v <= 0; mem_v <= 0; wb_v <= 0;
      id_rs <= 0; id_rt <= 0; id_im <= 0; ex_rt <= 0; ex_im <= 0; ex_opa <= 0;
      mem_rt <= 0; mem_res <= 0; wb_rt <= 0; wb_res <= 0;
      for (int k = 0; k < 8; k++) rf[k] <= 32'h0;
    end else if (pipe_mode) begin
      if (pc < prog_len) begin
        id_v <= 1; id_rs <= prog_rs[pc]; id_rt <= prog_rt[pc]; id_im <= prog_im[pc];
        pc <= pc + 1;
      end else id_v <= 0;
      ex_v <= id_v; ex_rt <= id_rt; ex_im <= id_im; ex_opa <= o_a;
      mem_v <= ex_v; mem_rt <= ex_rt; mem_res <= ex_res;
      wb_v <= mem_v; wb_rt <= mem_rt; wb_res <= mem_res;
      if (wb_v && wb_rt != 5'd0) rf[wb_rt[2:0]] <= wb_res;
    end
  end

  // independent statement of R1..R7
  function automatic logic [31:0] expect_opnd(logic en, logic [4:0] a, logic [31:0] rfd,
      logic xwe, logic [4:0] xa, logic [31:0] xd, logic mwe, logic [4:0] ma, logic [31:0] md);
    if (en == 1'b0) return 32'h0;
    if (a == 5'd0) return 32'h0;
    if (xwe && xa == a) return xd;
    if (mwe && ma == a) return md;
    return rfd;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(string req, logic ea, logic [4:0] aa, logic eb, logic [4:0] ab,
                       logic xwe, logic [4:0] xa, logic mwe, logic [4:0] ma);
    @(negedge clk);
    t_en_a = ea; t_ad_a = aa; t_en_b = eb; t_ad_b = ab;
    t_exwe = xwe; t_exa = xa; t_mwe = mwe; t_ma = ma;
    t_rf_a = $urandom; t_rf_b = $urandom; t_exd = $urandom; t_md = $urandom;
    #1;
    check({req, " port A"}, o_a, expect_opnd(ea, aa, t_rf_a, xwe, xa, t_exd, mwe, ma, t_md));
    check({req, " port B"}, o_b, expect_opnd(eb, ab, t_rf_b, xwe, xa, t_exd, mwe, ma, t_md));
  endtask

  task automatic run_prog(string tag);
    logic [31:0] model [8];
    for (int k = 0; k < 8; k++) model[k] = 32'h0;
    for (int k = 0; k < prog_len; k++)
      if (prog_rt[k] != 5'd0) model[prog_rt[k][2:0]] = model[prog_rs[k][2:0]] | {16'h0, prog_im[k]};
    @(negedge clk); pipe_clr = 1; @(negedge clk); pipe_clr = 0; pipe_mode = 1;
    repeat (prog_len + 6) @(negedge clk);
    pipe_mode = 0;
    for (int k = 1; k < 8; k++) check({"R9 ", tag}, rf[k], model[k]);
  endtask

  task automatic put(int i, int rt, int rs, int im);
    prog_rt[i] = rt[4:0]; prog_rs[i] = rs[4:0]; prog_im[i] = im[15:0];
  endtask

  initial begin
    void'($urandom(32'd1234));
    t_en_a = 0; t_en_b = 0; t_exwe = 0; t_mwe = 0;
    t_ad_a = 0; t_ad_b = 0; t_exa = 0; t_ma = 0;
    t_rf_a = 0; t_rf_b = 0; t_exd = 0; t_md = 0;
    repeat (2) @(negedge clk);
    #1;
    check("R1 idle", o_a, 32'h0);
    check("R1 idle", o_b, 32'h0);
    // directed corners
    apply("R1 disabled with hits", 0, 5'd3, 0, 5'd3, 1, 5'd3, 1, 5'd3);
    apply("R2 reg0 both stages", 1, 5'd0, 1, 5'd0, 1, 5'd0, 1, 5'd0);
    apply("R3 ex only", 1, 5'd7, 1, 5'd7, 1, 5'd7, 0, 5'd7);
    apply("R4 mem only", 1, 5'd9, 1, 5'd9, 0, 5'd1, 1, 5'd9);
    apply("R5 both match", 1, 5'd4, 1, 5'd4, 1, 5'd4, 1, 5'd4);
    apply("R6 no match", 1, 5'd6, 1, 5'd31, 1, 5'd5, 1, 5'd8);
    apply("R7 idle stages same addr", 1, 5'd2, 1, 5'd2, 0, 5'd2, 0, 5'd2);
    apply("R8 ports differ", 1, 5'd10, 1, 5'd11, 1, 5'd10, 1, 5'd11);
    apply("R8 ex vs rf", 1, 5'd12, 1, 5'd13, 1, 5'd12, 0, 5'd13);
    // random with dense collisions
    for (int n = 0; n < 400; n++)
      apply("R3/R4/R5/R6/R7 random", 1'($urandom), 5'($urandom % 4), 1'($urandom), 5'($urandom % 4),
            1'($urandom), 5'($urandom % 4), 1'($urandom), 5'($urandom % 4));
    // R9 distance one
    put(0, 1, 0, 16'h1100); put(1, 2, 1, 16'h0020); prog_len = 2;
    run_prog("distance 1");
    // distance two
    put(0, 1, 0, 16'h1100); put(1, 3, 0, 16'hffff); put(2, 2, 1, 16'h0020); prog_len = 3;
    run_prog("distance 2");
    // distance three
    put(0, 1, 0, 16'h1100); put(1, 3, 0, 16'hffff); put(2, 4, 0, 16'hffff);
    put(3, 2, 1, 16'h0020); prog_len = 4;
    run_prog("distance 3");
    // same register rewritten twice in a row, then read: execute must beat memory
    put(0, 5, 0, 16'h0001); put(1, 5, 5, 16'h0100); put(2, 6, 5, 16'h8000);
    put(3, 0, 6, 16'h1234); put(4, 7, 0, 16'h0002); prog_len = 5;
    run_prog("chain and r0");
    for (int k = 0; k < 40; k++) put(k, $urandom % 8, $urandom % 8, $urandom % 65536);
    prog_len = 40;
    run_prog("random program");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule